// File: doc/BRIEF.md
# Pipeline operand forwarding unit

This block chooses where each ALU source operand of the instruction now in the execute stage comes from in a five-stage in-order integer pipeline. There are three possible sources. The first is the value read from the register file. The second is the result waiting in the register between execute and memory access, here called the EX/MEM slot. The third is the value waiting in the register between memory access and write-back, here called the MEM/WB slot. Each of the two operands is resolved on its own. Each one gets a 2-bit select code, which the block also applies to an operand multiplexer so the chosen value can be observed.

A bypass is needed when an older instruction, one or two stages ahead, is about to write a register that the execute-stage instruction reads. When both older instructions target that register, the younger one, in EX/MEM, supplies the value. A producer that has already reached write-back needs no bypass, because the register file writes and then reads in the same cycle. For a load in MEM/WB, the bypassed value is the memory read data rather than the ALU result. A memory-to-register control bit picks between the two.

The block is purely combinational. Stalling, branch resolution and the register file itself belong to other blocks.

Top module: `fwd_unit`

## Requirements
- R1: When neither downstream slot qualifies for a source register, that operand's select is 2'b00 and the operand equals the register-file value.
- R2: When the EX/MEM slot has its write enable high and a non-zero destination equal to the source register, the select is 2'b10 and the operand equals the EX/MEM result.
- R3: When only the MEM/WB slot qualifies (write enable high, non-zero destination equal to the source register), the select is 2'b01 and the operand equals the MEM/WB value.
- R4: When both slots qualify for the same source register, the EX/MEM slot wins and the select is 2'b10.
- R5: A destination of register 0 is never forwarded from either slot, whatever the write enables are.
- R6: A slot whose write enable is low is never forwarded, even if its destination matches.
- R7: The MEM/WB value is the load data when the memory-to-register bit is 1, and the ALU result when it is 0.
- R8: The two operands are resolved independently. When both name the same register, they receive the same select and the same value.
- R9: Only the codes 2'b00, 2'b01 and 2'b10 ever appear on a select output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | 5 | First source register number of the execute-stage instruction |
| src_b_i | input | 5 | Second source register number of the execute-stage instruction |
| exm_dst_i | input | 5 | Destination register held in the EX/MEM slot |
| exm_we_i | input | 1 | Register-write enable of the EX/MEM slot |
| exm_res_i | input | 32 | Result held in the EX/MEM slot |
| mwb_dst_i | input | 5 | Destination register held in the MEM/WB slot |
| mwb_we_i | input | 1 | Register-write enable of the MEM/WB slot |
| mwb_alu_i | input | 32 | ALU result held in the MEM/WB slot |
| mwb_ld_i | input | 32 | Load data held in the MEM/WB slot |
| mwb_m2r_i | input | 1 | Memory-to-register bit of the MEM/WB slot (1 = load data) |
| rf_a_i | input | 32 | Register-file read value for the first operand |
| rf_b_i | input | 32 | Register-file read value for the second operand |
| sel_a_o | output | 2 | Source select for the first operand (00 file, 10 EX/MEM, 01 MEM/WB) |
| sel_b_o | output | 2 | Source select for the second operand |
| opnd_a_o | output | 32 | Selected first operand |
| opnd_b_o | output | 32 | Selected second operand |

## Verification
Two situations can fall in the same cycle. In the first, both slots claim the same source register, so the priority rule has to settle it. In the second, the two operands pull from different slots at once, so each selector has to ignore what the other one picks. The bench provokes both with directed vectors where one operand hits EX/MEM while the other hits MEM/WB, and where both slots write the same register. It also draws random register numbers from a narrow range, so that matches and overlaps are frequent. Every select and operand is compared against a bench model that applies the priority order separately for each operand.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MWB = 2'b01,
    SRC_EXM = 2'b10
  } src_sel_e;
endpackage

// File: rtl/fwd_wb_value.sv
module fwd_wb_value #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] alu_i,
  input  logic [XLEN-1:0] ld_i,
  input  logic            m2r_i,
  output logic [XLEN-1:0] val_o
);
  always_comb begin
    val_o = m2r_i ? ld_i : alu_i;
    p_load_pick_r7: assert (!m2r_i || val_o == ld_i)
      else $error("load data not chosen");
  end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] exm_dst_i,
  input  logic          exm_we_i,
  input  logic [AW-1:0] mwb_dst_i,
  input  logic          mwb_we_i,
  output src_sel_e      sel_o
);
  logic exm_hit, mwb_hit;

  always_comb begin
    exm_hit = exm_we_i && (exm_dst_i != '0) && (exm_dst_i == src_i);
    mwb_hit = mwb_we_i && (mwb_dst_i != '0) && (mwb_dst_i == src_i);
    // youngest producer first
    if (exm_hit)      sel_o = SRC_EXM;
    else if (mwb_hit) sel_o = SRC_MWB;
    else              sel_o = SRC_RF;

    p_code_r9: assert (sel_o == SRC_RF || sel_o == SRC_MWB || sel_o == SRC_EXM)
      else $error("illegal select code");
    p_zero_r5: assert (sel_o == SRC_RF || src_i != '0)
      else $error("register 0 forwarded");
    p_exm_we_r6: assert (sel_o != SRC_EXM || exm_we_i)
      else $error("EX/MEM forwarded without write enable");
    p_mwb_we_r6: assert (sel_o != SRC_MWB || mwb_we_i)
      else $error("MEM/WB forwarded without write enable");
    p_youngest_r4: assert (!(exm_we_i && exm_dst_i == src_i && src_i != '0)
                           || sel_o == SRC_EXM)
      else $error("EX/MEM lost priority");
    p_mwb_match_r3: assert (sel_o != SRC_MWB || (mwb_dst_i == src_i && exm_dst_i != src_i)
                            || !exm_we_i)
      else $error("MEM/WB chosen over a live EX/MEM match");
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  src_sel_e        sel_i,
  input  logic [XLEN-1:0] rf_i,
  input  logic [XLEN-1:0] exm_i,
  input  logic [XLEN-1:0] mwb_i,
  output logic [XLEN-1:0] opnd_o
);
  always_comb begin
    unique case (sel_i)
      SRC_EXM: opnd_o = exm_i;
      SRC_MWB: opnd_o = mwb_i;
      default: opnd_o = rf_i;
    endcase
    p_exm_pass_r2: assert (sel_i != SRC_EXM || opnd_o == exm_i)
      else $error("EX/MEM value not passed");
    p_rf_pass_r1: assert (sel_i != SRC_RF || opnd_o == rf_i)
      else $error("register-file value not passed");
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int AW   = 5,
  parameter int XLEN = 32
) (
  input  logic [AW-1:0]   src_a_i,
  input  logic [AW-1:0]   src_b_i,
  input  logic [AW-1:0]   exm_dst_i,
  input  logic            exm_we_i,
  input  logic [XLEN-1:0] exm_res_i,
  input  logic [AW-1:0]   mwb_dst_i,
  input  logic            mwb_we_i,
  input  logic [XLEN-1:0] mwb_alu_i,
  input  logic [XLEN-1:0] mwb_ld_i,
  input  logic            mwb_m2r_i,
  input  logic [XLEN-1:0] rf_a_i,
  input  logic [XLEN-1:0] rf_b_i,
  output logic [1:0]      sel_a_o,
  output logic [1:0]      sel_b_o,
  output logic [XLEN-1:0] opnd_a_o,
  output logic [XLEN-1:0] opnd_b_o
);
  localparam int NSRC = 2;

  logic [XLEN-1:0] mwb_val;
  logic [AW-1:0]   src   [NSRC];
  logic [XLEN-1:0] rf    [NSRC];
  logic [XLEN-1:0] opnd  [NSRC];
  src_sel_e        sel   [NSRC];

  assign src[0] = src_a_i;
  assign src[1] = src_b_i;
  assign rf[0]  = rf_a_i;
  assign rf[1]  = rf_b_i;

  fwd_wb_value #(.XLEN(XLEN)) u_wbv (
    .alu_i (mwb_alu_i),
    .ld_i  (mwb_ld_i),
    .m2r_i (mwb_m2r_i),
    .val_o (mwb_val)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    fwd_operand_sel #(.AW(AW)) u_sel (
      .src_i     (src[g]),
      .exm_dst_i (exm_dst_i),
      .exm_we_i  (exm_we_i),
      .mwb_dst_i (mwb_dst_i),
      .mwb_we_i  (mwb_we_i),
      .sel_o     (sel[g])
    );
    fwd_operand_mux #(.XLEN(XLEN)) u_mux (
      .sel_i  (sel[g]),
      .rf_i   (rf[g]),
      .exm_i  (exm_res_i),
      .mwb_i  (mwb_val),
      .opnd_o (opnd[g])
    );
  end

  assign sel_a_o  = sel[0];
  assign sel_b_o  = sel[1];
  assign opnd_a_o = opnd[0];
  assign opnd_b_o = opnd[1];
endmodule

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;
  localparam int AW = 5;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0]   src_a, src_b, exm_dst, mwb_dst;
  logic            exm_we, mwb_we, mwb_m2r;
  logic [XLEN-1:0] exm_res, mwb_alu, mwb_ld, rf_a, rf_b;
  logic [1:0]      sel_a, sel_b;
  logic [XLEN-1:0] opnd_a, opnd_b;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  fwd_unit #(.AW(AW), .XLEN(XLEN)) u0 (
    .src_a_i(src_a), .src_b_i(src_b),
    .exm_dst_i(exm_dst), .exm_we_i(exm_we), .exm_res_i(exm_res),
    .mwb_dst_i(mwb_dst), .mwb_we_i(mwb_we), .mwb_alu_i(mwb_alu),
    .mwb_ld_i(mwb_ld), .mwb_m2r_i(mwb_m2r),
    .rf_a_i(rf_a), .rf_b_i(rf_b),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .opnd_a_o(opnd_a), .opnd_b_o(opnd_b)
  );

  function automatic logic [1:0] ref_sel(logic [AW-1:0] s);
    if (exm_we && exm_dst != 0 && exm_dst == s) return 2'b10;
    if (mwb_we && mwb_dst != 0 && mwb_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [XLEN-1:0] ref_val(logic [1:0] c, logic [XLEN-1:0] rf);
    case (c)
      2'b10:   return exm_res;
      2'b01:   return mwb_m2r ? mwb_ld : mwb_alu;
      default: return rf;
    endcase
  endfunction

  task automatic drive(input logic [AW-1:0] sa, sb, ed, input logic ew,
                       input logic [AW-1:0] md, input logic mw, input logic m2r);
    @(posedge clk);
    src_a = sa; src_b = sb; exm_dst = ed; exm_we = ew;
    mwb_dst = md; mwb_we = mw; mwb_m2r = m2r;
    exm_res = $urandom; mwb_alu = $urandom; mwb_ld = $urandom;
    rf_a = $urandom; rf_b = $urandom;
  endtask

  task automatic check(input string tag);
    logic [1:0] ea, eb;
    @(negedge clk);
    ea = ref_sel(src_a);
    eb = ref_sel(src_b);
    n_vec++;
    if (sel_a !== ea || opnd_a !== ref_val(ea, rf_a)) begin
      n_bad++;
      $display("FAIL %s operand a: sel=%b val=%h expected sel=%b val=%h",
               tag, sel_a, opnd_a, ea, ref_val(ea, rf_a));
    end
    if (sel_b !== eb || opnd_b !== ref_val(eb, rf_b)) begin
      n_bad++;
      $display("FAIL %s operand b: sel=%b val=%h expected sel=%b val=%h",
               tag, sel_b, opnd_b, eb, ref_val(eb, rf_b));
    end
  endtask

  task automatic vec(input string tag, input logic [AW-1:0] sa, sb, ed,
                     input logic ew, input logic [AW-1:0] md, input logic mw,
                     input logic m2r, input logic [1:0] wa, wb);
    drive(sa, sb, ed, ew, md, mw, m2r);
    check(tag);
    // directed expectation on the select codes themselves
    if (sel_a !== wa || sel_b !== wb) begin
      n_bad++;
      $display("FAIL %s codes: a=%b b=%b expected a=%b b=%b", tag, sel_a, sel_b, wa, wb);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: no producer matches -> 00, file value
    vec("R1", 5'd3, 5'd4, 5'd7, 1'b1, 5'd8, 1'b1, 1'b0, 2'b00, 2'b00);
    // R2: EX/MEM match on operand a
    vec("R2", 5'd6, 5'd4, 5'd6, 1'b1, 5'd9, 1'b1, 1'b0, 2'b10, 2'b00);
    // R3: MEM/WB match on operand b, ALU result
    vec("R3", 5'd2, 5'd11, 5'd1, 1'b1, 5'd11, 1'b1, 1'b0, 2'b00, 2'b01);
    // R4: both slots write the same register
    vec("R4", 5'd5, 5'd5, 5'd5, 1'b1, 5'd5, 1'b1, 1'b1, 2'b10, 2'b10);
    // R5: destination 0 in both slots
    vec("R5", 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1, 2'b00, 2'b00);
    // R6: matching destinations with enables low
    vec("R6", 5'd9, 5'd10, 5'd9, 1'b0, 5'd10, 1'b0, 1'b0, 2'b00, 2'b00);
    // R6: EX/MEM disabled, MEM/WB enabled on same register
    vec("R6", 5'd9, 5'd9, 5'd9, 1'b0, 5'd9, 1'b1, 1'b0, 2'b01, 2'b01);
    // R7: load forwarded from MEM/WB takes load data
    vec("R7", 5'd12, 5'd1, 5'd3, 1'b1, 5'd12, 1'b1, 1'b1, 2'b01, 2'b00);
    // R8: operands from different slots in the same cycle
    vec("R8", 5'd14, 5'd15, 5'd14, 1'b1, 5'd15, 1'b1, 1'b1, 2'b10, 2'b01);
    // R8: same register on both operands
    vec("R8", 5'd20, 5'd20, 5'd2, 1'b1, 5'd20, 1'b1, 1'b0, 2'b01, 2'b01);
    // R9 and R8: random, narrow register range for frequent overlap
    for (int i = 0; i < 3000; i++) begin
      drive(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
            AW'($urandom_range(0, 3)), 1'($urandom), AW'($urandom_range(0, 3)),
            1'($urandom), 1'($urandom));
      check("R8");
      if (sel_a === 2'b11 || sel_b === 2'b11) begin
        n_bad++;
        $display("FAIL R9 code 11: a=%b b=%b expected not 11", sel_a, sel_b);
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule